// File: doc/BRIEF.md
# Serial ADC Output Shifter

This block is the device-side serial output stage of a 14-bit sampling converter. It is written as a synthesizable peripheral model, so that a serial master can be tested against realistic device behaviour. A local system clock oversamples the chip-select and serial-clock pins. On the falling edge of chip select it captures a parallel result and two sub-bits. It then presents one bit per serial-clock falling edge on a data line. The master samples that line on the rising edge.

Each frame is 24 bits long. It opens with eight zero bits. The 14 result bits follow, most significant first, and then the two sub-bits. Once the frame is complete, the line carries zeros for as long as chip select stays low. While chip select is high, the output enable is low, so the pad floats. The analog conversion is not part of this block.

The control core is a five-state machine: ST_IDLE, ST_LEAD, ST_DATA, ST_SUB and ST_TAIL. Its transitions are:
- T_START: ST_IDLE to ST_LEAD on a chip-select fall.
- T_ABORT: any frame state to ST_IDLE while chip select is high.
- T_LEAD_TO_DATA, T_DATA_TO_SUB and T_SUB_TO_TAIL: taken on the serial-clock fall that moves the bit count into the next section.
- T_HOLD: stay in the current state.

A saturating bit counter selects the section and holds at 24.

Top module: `adc_serial_out`

## Requirements
- R1: While the synchronised chip select is high, dout_oe is 0 and dout is 0. Both take effect no later than SYNC_STAGES+1 clk cycles after cs_n rises.
- R2: Inside a frame, dout changes only after a falling edge of sclk. A rising edge or a held level of sclk leaves it unchanged.
- R3: The frame bit order is 8 zeros, then sample[13] down to sample[0], then sub_bits[1] and then sub_bits[0], for 24 bits.
- R4: After the 24th bit, every further sclk falling edge with cs_n low gives dout = 0. The bit counter stays at 24.
- R5: Raising cs_n mid-frame ends the frame. The next falling edge of cs_n restarts from the first leading zero.
- R6: The first bit of a frame is on dout, with dout_oe = 1, SYNC_STAGES+1 clk cycles after cs_n falls, before any sclk edge.
- R7: sample and sub_bits are captured when the cs_n fall is detected. Later changes to them do not alter the frame in progress.
- R8: sclk activity while cs_n is high has no effect. The following frame still starts at its first bit.
- R9: While rst_n is low, and right after it is released, dout_oe and dout are 0. This holds even mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the master, asynchronous to clk |
| sample | input | 14 | Parallel conversion result |
| sub_bits | input | 2 | Two sub-bits appended after the result |
| dout | output | 1 | Serial data value, 0 when not enabled |
| dout_oe | output | 1 | Output enable for the data pad |

## Verification
The bench builds the block with its default parameters: 8 leading zeros, a 14-bit result, 2 sub-bits and a two-stage synchroniser. This gives a 24-bit frame and a 5-bit counter that saturates at 24. A full frame plus four trailing bits is read for each vector, so the section boundaries at bits 8, 22 and 24 and the saturation point are all exercised. The serial clock runs at one sixteenth of the system clock. This leaves enough margin for the three-cycle synchroniser and edge-detect latency, and makes the rising-edge hold check in R2 observable.

// File: rtl/adc_sout_pkg.sv
package adc_sout_pkg;

    // Frame sections of the serial output sequence.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_DATA = 3'd2,
        ST_SUB  = 3'd3,
        ST_TAIL = 3'd4
    } sout_state_e;

    // Index of each pin inside the synchroniser vector.
    localparam int PIN_CS   = 0;
    localparam int PIN_SCLK = 1;
    localparam int N_PINS   = 2;

endpackage

// File: rtl/adc_sout_sync.sv
module adc_sout_sync #(
    parameter int              N_SIG   = 2,
    parameter int              STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] pin_in,
    output logic [N_SIG-1:0] lvl,
    output logic [N_SIG-1:0] lvl_d
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        logic              hold;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
                hold  <= RST_VAL[g];
            end else begin
                if (STAGES > 1) begin
                    chain <= {chain[STAGES-2:0], pin_in[g]};
                end else begin
                    chain <= pin_in[g];
                end
                hold <= chain[STAGES-1];
            end
        end

        assign lvl[g]   = chain[STAGES-1];
        assign lvl_d[g] = hold;
    end

endmodule

// File: rtl/adc_sout_frame.sv
module adc_sout_frame #(
    parameter int LEAD_W = 8,
    parameter int RES_W  = 14,
    parameter int SUB_W  = 2,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [RES_W-1:0] sample,
    input  logic [SUB_W-1:0] sub_bits,
    output logic             head_bit,
    output logic [CNT_W-1:0] cnt
);

    localparam int               FRAME_W = LEAD_W + RES_W + SUB_W;
    localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] load_word;

    // Leading zeros occupy the top of the word; zeros also fill from below.
    assign load_word = {{LEAD_W{1'b0}}, sample, sub_bits};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (load) begin
            shreg <= load_word;
            cnt   <= '0;
        end else if (shift) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            if (cnt != FRAME_C) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign head_bit = shreg[FRAME_W-1];

endmodule

// File: rtl/adc_sout_fsm.sv
module adc_sout_fsm
    import adc_sout_pkg::*;
#(
    parameter int LEAD_W = 8,
    parameter int RES_W  = 14,
    parameter int SUB_W  = 2,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_lvl,
    input  logic             cs_fall,
    input  logic             sclk_fall,
    input  logic [CNT_W-1:0] cnt,
    output sout_state_e      state,
    output logic             load,
    output logic             shift,
    output logic             drive,
    output logic             zero_sel
);

    localparam int               FRAME_W    = LEAD_W + RES_W + SUB_W;
    localparam logic [CNT_W-1:0] LEAD_C     = CNT_W'(LEAD_W);
    localparam logic [CNT_W-1:0] DATA_END_C = CNT_W'(LEAD_W + RES_W);
    localparam logic [CNT_W-1:0] FRAME_C    = CNT_W'(FRAME_W);

    sout_state_e      state_nxt;
    logic [CNT_W-1:0] cnt_after;

    function automatic sout_state_e section_of(input logic [CNT_W-1:0] c);
        if (c < LEAD_C) begin
            return ST_LEAD;
        end else if (c < DATA_END_C) begin
            return ST_DATA;
        end else if (c < FRAME_C) begin
            return ST_SUB;
        end
        return ST_TAIL;
    endfunction

    assign cnt_after = (cnt == FRAME_C) ? cnt : cnt + 1'b1;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: T_START, T_ABORT, section advances, T_HOLD.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cs_fall) begin
                    state_nxt = section_of('0);
                end
            end
            ST_LEAD, ST_DATA, ST_SUB: begin
                if (cs_lvl) begin
                    state_nxt = ST_IDLE;
                end else if (sclk_fall) begin
                    state_nxt = section_of(cnt_after);
                end
            end
            ST_TAIL: begin
                if (cs_lvl) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Per-state controls.
    always_comb begin
        load     = 1'b0;
        shift    = 1'b0;
        drive    = 1'b0;
        zero_sel = 1'b1;
        unique case (state)
            ST_IDLE: begin
                load = cs_fall;
            end
            ST_LEAD, ST_DATA, ST_SUB: begin
                drive    = 1'b1;
                zero_sel = 1'b0;
                shift    = sclk_fall & ~cs_lvl;
            end
            ST_TAIL: begin
                drive = 1'b1;
            end
            default: begin
                drive = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/adc_serial_out.sv
module adc_serial_out
    import adc_sout_pkg::*;
#(
    parameter int LEAD_W      = 8,
    parameter int RES_W       = 14,
    parameter int SUB_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] sample,
    input  logic [SUB_W-1:0] sub_bits,
    output logic             dout,
    output logic             dout_oe
);

    localparam int FRAME_W = LEAD_W + RES_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [N_PINS-1:0] pins;
    logic [N_PINS-1:0] pins_lvl;
    logic [N_PINS-1:0] pins_lvl_d;
    logic              cs_lvl;
    logic              cs_fall;
    logic              sclk_fall;
    logic [CNT_W-1:0]  cnt;
    logic              head_bit;
    logic              load;
    logic              shift;
    logic              drive;
    logic              zero_sel;
    sout_state_e       state;

    assign pins[PIN_CS]   = cs_n;
    assign pins[PIN_SCLK] = sclk;

    // Chip select idles high, serial clock idles low.
    adc_sout_sync #(
        .N_SIG   (N_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (N_PINS'(1) << PIN_CS)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pins),
        .lvl    (pins_lvl),
        .lvl_d  (pins_lvl_d)
    );

    assign cs_lvl    = pins_lvl[PIN_CS];
    assign cs_fall   = pins_lvl_d[PIN_CS]   & ~pins_lvl[PIN_CS];
    assign sclk_fall = pins_lvl_d[PIN_SCLK] & ~pins_lvl[PIN_SCLK];

    adc_sout_fsm #(
        .LEAD_W (LEAD_W),
        .RES_W  (RES_W),
        .SUB_W  (SUB_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (cs_lvl),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall),
        .cnt       (cnt),
        .state     (state),
        .load      (load),
        .shift     (shift),
        .drive     (drive),
        .zero_sel  (zero_sel)
    );

    adc_sout_frame #(
        .LEAD_W (LEAD_W),
        .RES_W  (RES_W),
        .SUB_W  (SUB_W),
        .CNT_W  (CNT_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .sample   (sample),
        .sub_bits (sub_bits),
        .head_bit (head_bit),
        .cnt      (cnt)
    );

    assign dout_oe = drive;
    assign dout    = drive & ~zero_sel & head_bit;

endmodule

// File: rtl/adc_serial_out_chk.sv
module adc_serial_out_chk #(
    parameter int LEAD_W  = 8,
    parameter int FRAME_W = 24,
    parameter int CNT_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_lvl,
    input logic             cs_fall,
    input logic             sclk_fall,
    input logic [CNT_W-1:0] cnt,
    input logic             dout,
    input logic             dout_oe
);

    localparam logic [CNT_W-1:0] LEAD_C  = CNT_W'(LEAD_W);
    localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_W);

    p_desel_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> !dout_oe);

    p_quiet_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

    p_change_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(dout_oe) && !$past(sclk_fall)) |-> $stable(dout));

    p_lead_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && cnt < LEAD_C) |-> !dout);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FRAME_C);

    p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && cnt == FRAME_C) |-> !dout);

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (cnt == '0 && dout_oe));

endmodule

bind adc_serial_out adc_serial_out_chk #(
    .LEAD_W  (LEAD_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_lvl    (cs_lvl),
    .cs_fall   (cs_fall),
    .sclk_fall (sclk_fall),
    .cnt       (cnt),
    .dout      (dout),
    .dout_oe   (dout_oe)
);

// File: tb/adc_serial_out_tb.sv
module adc_serial_out_tb;

    localparam int HALF   = 8;
    localparam int NVEC   = 8;
    localparam int NREAD  = 28;

    // Each entry: {sample[13:0], sub_bits[1:0]}.
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555,
        16'h8001, 16'h1234, 16'h7FFE, 16'hC003
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [13:0] sample = '0;
    logic [1:0]  sub_bits = '0;
    logic        dout;
    logic        dout_oe;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    adc_serial_out u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sample   (sample),
        .sub_bits (sub_bits),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (HALF) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_sclk();
        sclk = 1'b1;
        settle();
        sclk = 1'b0;
        settle();
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        settle();
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        settle();
    endtask

    task automatic read_bits(input int nbits, output logic [31:0] bits);
        bits = '0;
        for (int i = 0; i < nbits; i++) begin
            if (i != 0) pulse_sclk();
            bits = {bits[30:0], dout};
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] got;
        logic [31:0] exp;

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dout_oe == 1'b0 && dout == 1'b0, "R9 in reset", {dout_oe, dout}, 0);
        rst_n = 1'b1;
        settle();
        check(dout_oe == 1'b0, "R9 after release", dout_oe, 0);

        // Vector table: full frame plus tail (R3, R4, R1)
        for (int v = 0; v < NVEC; v++) begin
            sample   = VEC[v][15:2];
            sub_bits = VEC[v][1:0];
            cs_low();
            read_bits(NREAD, got);
            exp = {8'h00, VEC[v], 4'h0};
            check(got[27:4] == exp[27:4], "R3 frame order", got[27:4], exp[27:4]);
            check(got[3:0] == 4'h0, "R4 trailing zeros", got[3:0], 0);
            cs_high();
            check(dout_oe == 1'b0 && dout == 1'b0, "R1 deselected", {dout_oe, dout}, 0);
        end

        // R8: sclk toggles while deselected are ignored
        sample = 14'h3FFF; sub_bits = 2'b11;
        for (int k = 0; k < 5; k++) pulse_sclk();
        check(dout_oe == 1'b0, "R8 no enable while deselected", dout_oe, 0);
        // R6: first bit present before any sclk edge
        cs_low();
        check(dout_oe == 1'b1 && dout == 1'b0, "R6 first bit ready", {dout_oe, dout}, 2);
        read_bits(24, got);
        check(got[23:0] == 24'h00FFFF, "R8 frame starts at bit 0", got[23:0], 24'h00FFFF);
        cs_high();

        // R2: rising edge and held level do not move the line
        sample = 14'h3FFF; sub_bits = 2'b00;
        cs_low();
        for (int k = 0; k < 7; k++) pulse_sclk();
        check(dout == 1'b0, "R2 last leading zero", dout, 0);
        sclk = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(dout == 1'b0, "R2 held after rising edge", dout, 0);
        sclk = 1'b0;
        settle();
        check(dout == 1'b1, "R2 changes after falling edge", dout, 1);
        cs_high();

        // R5: abort mid-frame, then restart from first leading zero
        sample = 14'h2A5C; sub_bits = 2'b10;
        cs_low();
        read_bits(12, got);
        exp = {8'h00, 14'h2A5C, 2'b10};
        check(got[11:0] == exp[23:12], "R5 partial frame", got[11:0], exp[23:12]);
        cs_high();
        check(dout_oe == 1'b0, "R5 abort floats line", dout_oe, 0);
        sample = 14'h1F0F; sub_bits = 2'b01;
        cs_low();
        read_bits(24, got);
        exp = {8'h00, 14'h1F0F, 2'b01};
        check(got[23:0] == exp[23:0], "R5 restart full frame", got[23:0], exp[23:0]);
        cs_high();

        // R7: sample changes during a frame are ignored
        sample = 14'h0ABC; sub_bits = 2'b11;
        cs_low();
        sample = 14'h3543; sub_bits = 2'b00;
        read_bits(24, got);
        exp = {8'h00, 14'h0ABC, 2'b11};
        check(got[23:0] == exp[23:0], "R7 latched sample", got[23:0], exp[23:0]);
        cs_high();

        // R9: reset mid-frame
        sample = 14'h3FFF; sub_bits = 2'b11;
        cs_low();
        for (int k = 0; k < 10; k++) pulse_sclk();
        rst_n = 1'b0;
        @(negedge clk);
        check(dout_oe == 1'b0 && dout == 1'b0, "R9 reset mid-frame", {dout_oe, dout}, 0);
        cs_n = 1'b1;
        settle();
        rst_n = 1'b1;
        settle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule